// File: doc/BRIEF.md
# NAND Page Reed-Solomon Parity Engine

This block sits beside a NAND flash data bus and computes Reed-Solomon parity over a 512-byte page while the bytes stream past. The code works on 10-bit symbols over GF(2^10) and adds six check symbols. Each data byte is complemented and zero-extended to one symbol before it enters a systematic divider. Because of this, an erased page of all-0xFF bytes encodes to all-zero parity, and that parity reads back as all-0xFF on the complemented view.

In generate mode the engine divides the page and holds the remainder for software to copy into the spare area. In check mode it divides the page again and then takes the eight stored parity bytes that follow the data. After the last of these bytes it compares the stored and computed parity and sets one error flag on a mismatch. Software controls the engine and reads results through a small register port of 16-bit words. Locating and correcting errors is done outside the block.

Top module: `rs_page_ecc`

## Requirements
- R1: After a generate pass over the 512 data bytes, the codeword must evaluate to zero at alpha^0 through alpha^5 in GF(2^10) with field polynomial 0x409. The codeword is formed from the complemented data bytes in arrival order (first byte at the highest degree), followed by the parity symbols from the x^5 coefficient down to x^0.
- R2: After reset or a clear, and after encoding an all-0xFF page, every complemented-view byte reads 0xFF. The true view then reads 0x00 in bytes 0..6 and 0x0F in byte 7.
- R3: Let N be the 64-bit value whose bits [10i+9:10i] hold the x^i parity coefficient and whose bits [63:60] are zero. True-view byte k is the bit reversal of N[8k+7:8k]. Complemented-view byte k is the bit reversal of ~N[8k+7:8k]. In both views the low four bits of byte 7 read as ones.
- R4: Every register reads as a 16-bit word with the upper byte zero. Word addresses: control at 0x50 (bit 6 generate, bit 5 feed; bit 7 reads 0), true view at 0x60+2k, check status at 0x70, complemented view at 0x80+2k.
- R5: Writing the control word with bit 7 set empties the remainder, the byte count and the error flag at that clock edge. Writing 0xE0 starts a generate pass, writing 0xA0 starts a check pass, and writing 0x00 freezes all state for readout.
- R6: A data strobe seen while the feed bit (bit 5) is low changes neither the remainder nor the byte count.
- R7: In generate mode only the first 512 accepted bytes enter the divider. Further strobes leave the parity unchanged.
- R8: In check mode bytes 513 to 520 are taken as stored parity in complemented-view format, with the byte-7 pad bits ignored. Status bit 7 of word 0x70 reads 1 exactly when the stored parity differs from the parity computed over the data.
- R9: The error flag changes only on the second clock edge after the 520th byte is accepted, or on a clear.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register word address, used for both read and write |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data, combinational from reg_addr |
| dat_valid | input | 1 | One flash data byte is present on dat_byte |
| dat_byte | input | 8 | Flash data bus byte |

## Verification
The bench first checks the parity through its algebraic property: a wrong generator, field polynomial or symbol order leaves a nonzero evaluation at some root. It then checks the bit-reversed packing by comparing the two views. Corruptions go after the packing edges: the first data byte, the last data byte, a middle parity byte, and a real bit and a pad bit of the final parity byte. A design that decoded the pad would flag an error on the pad-bit flip, and one that dropped the last stored byte would miss the real-bit flip. Directed tests feed bytes past the 512-byte limit and strobes with feed off, either of which would shift the parity in a faulty engine. They also sample the error flag one edge early, which catches a flag that is set before the comparison is due.

// File: rtl/rs_ecc_pkg.sv
package rs_ecc_pkg;

    localparam int SYM_W     = 10;
    localparam int NPAR      = 6;
    localparam int PAR_BITS  = SYM_W * NPAR;
    localparam int PAR_BYTES = (PAR_BITS + 7) / 8;
    localparam int PAD_BITS  = PAR_BYTES * 8 - PAR_BITS;
    localparam int IDX_W     = $clog2(PAR_BYTES);

    localparam logic [SYM_W:0] FIELD_POLY = 11'h409;

    localparam logic [7:0] A_CTL  = 8'h50;
    localparam logic [7:0] A_TRUE = 8'h60;
    localparam logic [7:0] A_CHK  = 8'h70;
    localparam logic [7:0] A_INV  = 8'h80;

    localparam int CTL_CLR  = 7;
    localparam int CTL_GEN  = 6;
    localparam int CTL_FEED = 5;
    localparam int CHK_ERR  = 7;

    typedef logic [SYM_W-1:0]             sym_t;
    typedef sym_t [NPAR-1:0]              rem_t;
    typedef logic [PAR_BYTES-1:0][7:0]    pbytes_t;

    typedef struct packed {
        logic gen;
        logic feed;
    } ctl_t;

    // multiply in GF(2^10)
    function automatic sym_t gf_mul(sym_t a, sym_t b);
        sym_t acc;
        sym_t x;
        acc = '0;
        x   = a;
        for (int i = 0; i < SYM_W; i++) begin
            if (b[i]) acc ^= x;
            x = x[SYM_W-1] ? ((x << 1) ^ FIELD_POLY[SYM_W-1:0]) : (x << 1);
        end
        return acc;
    endfunction

    // low coefficients of the monic generator prod (x + alpha^i), i = 0..NPAR-1
    function automatic rem_t gen_poly();
        sym_t g [NPAR+1];
        sym_t root;
        rem_t res;
        for (int j = 0; j <= NPAR; j++) g[j] = '0;
        g[0] = sym_t'(1);
        root = sym_t'(1);
        for (int i = 0; i < NPAR; i++) begin
            for (int j = NPAR; j > 0; j--) g[j] = g[j-1] ^ gf_mul(g[j], root);
            g[0] = gf_mul(g[0], root);
            root = gf_mul(root, sym_t'(2));
        end
        for (int j = 0; j < NPAR; j++) res[j] = g[j];
        return res;
    endfunction

    function automatic logic [7:0] rev8(logic [7:0] b);
        logic [7:0] r;
        for (int i = 0; i < 8; i++) r[i] = b[7-i];
        return r;
    endfunction

    // pack remainder into readout bytes; inv selects the complemented view
    function automatic pbytes_t pack_view(rem_t r, logic inv);
        logic [PAR_BYTES*8-1:0] n;
        logic [7:0]             b;
        pbytes_t                res;
        n = {{PAD_BITS{1'b0}}, r};
        for (int k = 0; k < PAR_BYTES; k++) begin
            b = n[8*k +: 8];
            if (inv) b = ~b;
            res[k] = rev8(b);
        end
        res[PAR_BYTES-1] = res[PAR_BYTES-1] | rev8(8'hFF << (8 - PAD_BITS));
        return res;
    endfunction

    // recover parity symbols from complemented-view bytes, pad dropped
    function automatic rem_t unpack_stored(pbytes_t s);
        logic [PAR_BYTES*8-1:0] n;
        for (int k = 0; k < PAR_BYTES; k++) n[8*k +: 8] = ~rev8(s[k]);
        return n[PAR_BITS-1:0];
    endfunction

endpackage

// File: rtl/rs_ecc_divider.sv
module rs_ecc_divider
    import rs_ecc_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       clr,
    input  logic       shift,
    input  logic [7:0] din,
    output rem_t       rem
);

    localparam rem_t GEN = gen_poly();

    rem_t rem_q;
    rem_t rem_nxt;
    sym_t fb;

    always_comb begin
        fb         = {{(SYM_W-8){1'b0}}, ~din} ^ rem_q[NPAR-1];
        rem_nxt[0] = gf_mul(fb, GEN[0]);
        for (int j = 1; j < NPAR; j++) begin
            rem_nxt[j] = rem_q[j-1] ^ gf_mul(fb, GEN[j]);
        end
    end

    always_ff @(posedge clk) begin
        if (rst || clr) rem_q <= '0;
        else if (shift) rem_q <= rem_nxt;
    end

    assign rem = rem_q;

endmodule

// File: rtl/rs_ecc_verify.sv
module rs_ecc_verify
    import rs_ecc_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic             cap,
    input  logic [IDX_W-1:0] cap_idx,
    input  logic             last,
    input  logic [7:0]       din,
    input  rem_t             rem,
    output logic             pend,
    output logic             err
);

    pbytes_t st_q;
    logic    pend_q;
    logic    err_q;

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            st_q   <= '0;
            pend_q <= 1'b0;
            err_q  <= 1'b0;
        end else begin
            if (cap) st_q[cap_idx] <= din;
            pend_q <= cap && last;
            if (pend_q) err_q <= (unpack_stored(st_q) != rem);
        end
    end

    assign pend = pend_q;
    assign err  = err_q;

endmodule

// File: rtl/rs_ecc_readout.sv
module rs_ecc_readout
    import rs_ecc_pkg::*;
(
    input  logic [7:0]  reg_addr,
    input  rem_t        rem,
    input  ctl_t        ctl,
    input  logic        err,
    output logic [15:0] reg_rdata
);

    pbytes_t tview;
    pbytes_t iview;
    logic    unused_addr;

    assign tview       = pack_view(rem, 1'b0);
    assign iview       = pack_view(rem, 1'b1);
    assign unused_addr = reg_addr[0];

    always_comb begin
        reg_rdata = '0;
        if (reg_addr[7:4] == A_TRUE[7:4]) begin
            reg_rdata[7:0] = tview[reg_addr[IDX_W:1]];
        end else if (reg_addr[7:4] == A_INV[7:4]) begin
            reg_rdata[7:0] = iview[reg_addr[IDX_W:1]];
        end else if (reg_addr[7:1] == A_CHK[7:1]) begin
            reg_rdata[CHK_ERR] = err;
        end else if (reg_addr[7:1] == A_CTL[7:1]) begin
            reg_rdata[CTL_GEN]  = ctl.gen;
            reg_rdata[CTL_FEED] = ctl.feed;
        end
    end

endmodule

// File: rtl/rs_page_ecc.sv
module rs_page_ecc
    import rs_ecc_pkg::*;
#(
    parameter int DATA_BYTES = 512
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        reg_wr,
    input  logic [7:0]  reg_addr,
    input  logic [15:0] reg_wdata,
    output logic [15:0] reg_rdata,
    input  logic        dat_valid,
    input  logic [7:0]  dat_byte
);

    localparam int TOTAL = DATA_BYTES + PAR_BYTES;
    localparam int CNT_W = $clog2(TOTAL + 1);

    ctl_t             ctl_q;
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] par_off;
    logic             ctl_wr;
    logic             clr;
    logic             take;
    logic             in_data;
    logic             in_par;
    logic             shift;
    logic             cap;
    logic             last;
    rem_t             rem;
    logic             chk_pend;
    logic             err;
    logic             unused_bits;

    assign ctl_wr  = reg_wr && (reg_addr == A_CTL);
    assign clr     = ctl_wr && reg_wdata[CTL_CLR];
    assign take    = dat_valid && ctl_q.feed && !clr;
    assign in_data = cnt_q < CNT_W'(DATA_BYTES);
    assign in_par  = !ctl_q.gen && !in_data && (cnt_q < CNT_W'(TOTAL));
    assign shift   = take && in_data;
    assign cap     = take && in_par;
    assign last    = cnt_q == CNT_W'(TOTAL - 1);
    assign par_off = cnt_q - CNT_W'(DATA_BYTES);

    assign unused_bits = ^{reg_wdata[15:8], reg_wdata[4:0], par_off[CNT_W-1:IDX_W]};

    always_ff @(posedge clk) begin
        if (rst) begin
            ctl_q <= '0;
        end else if (ctl_wr) begin
            ctl_q.gen  <= reg_wdata[CTL_GEN];
            ctl_q.feed <= reg_wdata[CTL_FEED];
        end
    end

    always_ff @(posedge clk) begin
        if (rst || clr)        cnt_q <= '0;
        else if (shift || cap) cnt_q <= cnt_q + 1'b1;
    end

    rs_ecc_divider u_div (
        .clk   (clk),
        .rst   (rst),
        .clr   (clr),
        .shift (shift),
        .din   (dat_byte),
        .rem   (rem)
    );

    rs_ecc_verify u_vfy (
        .clk     (clk),
        .rst     (rst),
        .clr     (clr),
        .cap     (cap),
        .cap_idx (par_off[IDX_W-1:0]),
        .last    (last),
        .din     (dat_byte),
        .rem     (rem),
        .pend    (chk_pend),
        .err     (err)
    );

    rs_ecc_readout u_rd (
        .reg_addr  (reg_addr),
        .rem       (rem),
        .ctl       (ctl_q),
        .err       (err),
        .reg_rdata (reg_rdata)
    );

endmodule

// File: rtl/rs_page_ecc_chk.sv
module rs_page_ecc_chk
    import rs_ecc_pkg::*;
#(
    parameter int DATA_BYTES = 512,
    parameter int CNT_W      = 10
) (
    input logic             clk,
    input logic             rst,
    input logic             clr,
    input logic             ctl_gen,
    input logic             ctl_feed,
    input logic [CNT_W-1:0] cnt,
    input rem_t             rem,
    input logic             err,
    input logic             pend,
    input logic [7:0]       reg_addr,
    input logic [15:0]      reg_rdata
);

    localparam int TOTAL = DATA_BYTES + PAR_BYTES;

    p_clear_empties_r5: assert property (@(posedge clk) disable iff (rst)
        clr |=> (cnt == '0 && !err && rem == '0));

    p_no_feed_hold_r6: assert property (@(posedge clk) disable iff (rst)
        (!clr && !ctl_feed) |=> ($stable(rem) && $stable(cnt)));

    p_gen_stops_r7: assert property (@(posedge clk) disable iff (rst)
        (!clr && ctl_gen && cnt == CNT_W'(DATA_BYTES)) |=> ($stable(rem) && $stable(cnt)));

    p_cnt_bound_r8: assert property (@(posedge clk) disable iff (rst)
        cnt <= CNT_W'(TOTAL));

    p_err_timing_r9: assert property (@(posedge clk) disable iff (rst)
        (!clr && !pend) |=> $stable(err));

    p_word_upper_r4: assert property (@(posedge clk) disable iff (rst)
        reg_rdata[15:8] == 8'h00);

    p_pad_ones_r3: assert property (@(posedge clk) disable iff (rst)
        (reg_addr == A_TRUE + 8'd14 || reg_addr == A_INV + 8'd14) |-> reg_rdata[3:0] == 4'hF);

endmodule

bind rs_page_ecc rs_page_ecc_chk #(
    .DATA_BYTES (DATA_BYTES),
    .CNT_W      (CNT_W)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .clr       (clr),
    .ctl_gen   (ctl_q.gen),
    .ctl_feed  (ctl_q.feed),
    .cnt       (cnt_q),
    .rem       (rem),
    .err       (err),
    .pend      (chk_pend),
    .reg_addr  (reg_addr),
    .reg_rdata (reg_rdata)
);

// File: tb/rs_page_ecc_tb.sv
module rs_page_ecc_tb;

    localparam int CLK_PERIOD = 10;
    localparam int NDATA      = 512;
    localparam logic [7:0] AC = 8'h50;
    localparam logic [7:0] AT = 8'h60;
    localparam logic [7:0] AK = 8'h70;
    localparam logic [7:0] AI = 8'h80;

    typedef struct packed {
        logic [1:0] kind;
        logic [7:0] seed;
        logic [9:0] hit;
        logic [7:0] flip;
        logic       exp_err;
    } vec_t;

    localparam int NV = 8;
    localparam vec_t VECS [NV] = '{
        '{2'd0, 8'h00, 10'd0,   8'h00, 1'b0},
        '{2'd2, 8'h5B, 10'd0,   8'h00, 1'b0},
        '{2'd2, 8'hC3, 10'd17,  8'h01, 1'b1},
        '{2'd3, 8'h2E, 10'd511, 8'h80, 1'b1},
        '{2'd2, 8'h91, 10'd515, 8'h10, 1'b1},
        '{2'd1, 8'h00, 10'd519, 8'h01, 1'b0},
        '{2'd1, 8'h00, 10'd519, 8'h80, 1'b1},
        '{2'd3, 8'h00, 10'd0,   8'hFF, 1'b1}
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_wr = 1'b0;
    logic [7:0]  reg_addr = 8'h00;
    logic [15:0] reg_wdata = 16'h0000;
    logic [15:0] reg_rdata;
    logic        dat_valid = 1'b0;
    logic [7:0]  dat_byte = 8'h00;

    int n_cmp = 0;
    int n_bad = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    rs_page_ecc u_dut (
        .clk       (clk),
        .rst       (rst),
        .reg_wr    (reg_wr),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .dat_valid (dat_valid),
        .dat_byte  (dat_byte)
    );

    function automatic logic [9:0] gm(logic [9:0] a, logic [9:0] b);
        logic [9:0] acc;
        logic [9:0] x;
        acc = '0;
        x   = a;
        for (int i = 0; i < 10; i++) begin
            if (b[i]) acc = acc ^ x;
            x = x[9] ? ({x[8:0], 1'b0} ^ 10'h009) : {x[8:0], 1'b0};
        end
        return acc;
    endfunction

    function automatic logic [7:0] rv(logic [7:0] b);
        return {b[0], b[1], b[2], b[3], b[4], b[5], b[6], b[7]};
    endfunction

    function automatic logic [7:0] pg(logic [1:0] kind, logic [7:0] seed, int i);
        logic [15:0] t;
        case (kind)
            2'd0: return 8'hFF;
            2'd1: return 8'h00;
            2'd2: begin
                t = 16'(i) * 16'd25173 + {8'h00, seed} * 16'd13849;
                return t[11:4] ^ seed;
            end
            default: return 8'(i) ^ seed;
        endcase
    endfunction

    // per-root nonzero flags of the codeword built from data and complemented view
    function automatic logic [5:0] syn_fail(logic [1:0] kind, logic [7:0] seed,
                                            logic [7:0][7:0] inv);
        logic [63:0] n;
        logic [9:0]  p [6];
        logic [9:0]  root;
        logic [9:0]  acc;
        logic [5:0]  f;
        for (int k = 0; k < 8; k++) n[8*k +: 8] = ~rv(inv[k]);
        for (int i = 0; i < 6; i++) p[i] = n[10*i +: 10];
        root = 10'd1;
        for (int r = 0; r < 6; r++) begin
            acc = '0;
            for (int i = 0; i < NDATA; i++) acc = gm(acc, root) ^ {2'b00, ~pg(kind, seed, i)};
            for (int j = 5; j >= 0; j--) acc = gm(acc, root) ^ p[j];
            f[r] = |acc;
            root = gm(root, 10'd2);
        end
        return f;
    endfunction

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr_ctl(input logic [15:0] v);
        @(negedge clk);
        reg_wr    = 1'b1;
        reg_addr  = AC;
        reg_wdata = v;
        @(negedge clk);
        reg_wr    = 1'b0;
    endtask

    task automatic feed(input logic [7:0] b);
        @(negedge clk);
        dat_valid = 1'b1;
        dat_byte  = b;
        @(negedge clk);
        dat_valid = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [15:0] d);
        @(negedge clk);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic read_views(output logic [63:0] tw, output logic [63:0] iw, output logic [63:0] hi);
        logic [15:0] d;
        hi = '0;
        for (int k = 0; k < 8; k++) begin
            rd(AT + 8'(2*k), d);
            tw[8*k +: 8] = d[7:0];
            hi[8*k +: 8] = hi[8*k +: 8] | d[15:8];
            rd(AI + 8'(2*k), d);
            iw[8*k +: 8] = d[7:0];
            hi[8*k +: 8] = hi[8*k +: 8] | d[15:8];
        end
    endtask

    task automatic finish_run();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog: run did not complete actual=hung expected=done");
        finish_run();
    end

    initial begin
        logic [63:0] tw, iw, hi, saved;
        logic [15:0] d;
        saved = '0;

        repeat (3) @(negedge clk);
        rst = 1'b0;

        // reset state
        read_views(tw, iw, hi);
        check("R2 reset true view", tw, 64'h0F00_0000_0000_0000);
        check("R2 reset complemented view", iw, 64'hFFFF_FFFF_FFFF_FFFF);
        check("R4 upper bytes zero", hi, 64'h0);
        rd(AK, d);
        check("R4 reset status word", 64'(d), 64'h0000);

        // vector table: generate, then check with optional corruption
        for (int v = 0; v < NV; v++) begin
            wr_ctl(16'h00E0);
            for (int i = 0; i < NDATA; i++) feed(pg(VECS[v].kind, VECS[v].seed, i));
            wr_ctl(16'h0000);
            read_views(tw, iw, hi);
            check("R1 codeword roots", 64'(syn_fail(VECS[v].kind, VECS[v].seed, iw)), 64'h0);
            check("R3 views complementary", tw ^ iw, 64'hF0FF_FFFF_FFFF_FFFF);
            check("R3 pad bits set", 64'({tw[59:56], iw[59:56]}), 64'hFF);
            if (VECS[v].kind == 2'd0)
                check("R2 blank page complemented view", iw, 64'hFFFF_FFFF_FFFF_FFFF);
            if (v == 1) saved = iw;

            wr_ctl(16'h00A0);
            for (int i = 0; i < NDATA + 8; i++) begin
                logic [7:0] b;
                b = (i < NDATA) ? pg(VECS[v].kind, VECS[v].seed, i) : iw[8*(i-NDATA) +: 8];
                if (i == int'(VECS[v].hit)) b = b ^ VECS[v].flip;
                feed(b);
            end
            repeat (3) @(negedge clk);
            rd(AK, d);
            check("R8 check flag", 64'(d), VECS[v].exp_err ? 64'h0080 : 64'h0000);
        end

        // R5: clear empties flag and remainder; control readback
        wr_ctl(16'h0080);
        rd(AK, d);
        check("R5 clear drops error flag", 64'(d), 64'h0000);
        read_views(tw, iw, hi);
        check("R5 clear empties remainder", tw, 64'h0F00_0000_0000_0000);
        wr_ctl(16'h00E0);
        rd(AC, d);
        check("R4 control readback", 64'(d), 64'h0060);

        // R6: strobes with feed off are ignored
        wr_ctl(16'h00C0);
        for (int i = 0; i < 20; i++) feed(8'(i * 7 + 3));
        read_views(tw, iw, hi);
        check("R6 strobes without feed", iw, 64'hFFFF_FFFF_FFFF_FFFF);

        // R7: bytes past the page end do not alter parity
        wr_ctl(16'h00E0);
        for (int i = 0; i < NDATA; i++) feed(pg(2'd2, 8'h5B, i));
        for (int i = 0; i < 8; i++) feed(8'h3C);
        wr_ctl(16'h0000);
        read_views(tw, iw, hi);
        check("R7 parity after extra bytes", iw, saved);

        // R9: flag timing relative to the final stored byte
        wr_ctl(16'h00A0);
        for (int i = 0; i < NDATA; i++) feed(pg(2'd2, 8'h5B, i) ^ ((i == 3) ? 8'h04 : 8'h00));
        for (int k = 0; k < 7; k++) feed(saved[8*k +: 8]);
        repeat (3) @(negedge clk);
        rd(AK, d);
        check("R9 flag low before last stored byte", 64'(d), 64'h0000);
        feed(saved[63:56]);
        reg_addr = AK;
        #1;
        check("R9 flag low one edge after last byte", 64'(reg_rdata), 64'h0000);
        @(negedge clk);
        #1;
        check("R9 flag set two edges after last byte", 64'(reg_rdata), 64'h0080);

        // R5: freeze keeps flag, clear drops it
        wr_ctl(16'h0000);
        for (int i = 0; i < 4; i++) feed(8'h55);
        rd(AK, d);
        check("R5 freeze holds flag", 64'(d), 64'h0080);
        wr_ctl(16'h0080);
        rd(AK, d);
        check("R5 clear after failure", 64'(d), 64'h0000);

        finish_run();
    end

endmodule